// File: doc/BRIEF.md
# Eight-Function ALU with Flags

This block is a purely combinational arithmetic-logic unit. Two operands of equal width go in, along with a 3-bit function select. One result word and a 4-bit condition vector come out. The unit offers two arithmetic functions, addition and subtraction, and six bitwise functions, three of which are inverted forms. The default operand width is 16 bits.

Subtraction is carried out by the same adder as addition. The adder is fed the first operand, the bitwise complement of the second operand and a carry-in of one. Because of this, one set of carry and overflow rules serves both arithmetic functions. The zero and negative conditions come from the final result for every function. Carry and overflow are cleared for every bitwise function. The block holds no state, so it can sit in any pipeline stage that needs it.

Top module: `octo_alu`

## Requirements
- R1: With select 3'b000 the result equals (A + B) modulo 2^WIDTH.
- R2: With select 3'b001 the result equals (A + ~B + 1) modulo 2^WIDTH, which is A - B in two's complement.
- R3: Selects 3'b010, 3'b011 and 3'b110 give the bitwise AND, XOR and OR of A and B.
- R4: Selects 3'b100, 3'b101 and 3'b111 give the bitwise NAND, XNOR and NOR of A and B.
- R5: Flag bit 3 (zero) is 1 exactly when every result bit is 0, for all eight functions.
- R6: Flag bit 2 (negative) equals the most significant result bit, for all eight functions.
- R7: Flag bit 1 (carry) is the carry out of the top bit of the adder. For 3'b000 the adder sums A and B. For 3'b001 it sums A, ~B and a carry-in of 1, so carry is 1 exactly when A >= B as unsigned numbers. Carry is 0 for all six bitwise functions.
- R8: Flag bit 0 (overflow) is 1 when the two addends share a sign bit and the sum's sign bit differs from it. Equivalently, the signed sum (3'b000) or signed difference (3'b001) falls outside the two's complement range. Overflow is 0 for all six bitwise functions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| fn_sel | input | 3 | Function select, encoded as listed in R1 to R4 |
| result | output | WIDTH | Function result |
| flags | output | 4 | Condition vector {zero, negative, carry, overflow}, zero in the MSB |

## Verification
The bench builds two copies of the block. One has WIDTH = 4, small enough that every operand pair under all eight functions can be swept exhaustively. That sweep reaches every carry and overflow boundary of the adder, in both directions, for addition and for subtraction. The other copy keeps the default WIDTH = 16 and crosses the boundary words 0x0000, 0xFFFF, 0x7FFF and 0x8000, plus 0x0001 and a set of pseudo-random words, under every function. This confirms that the top bit is chosen correctly at full width. Expected results come from integer arithmetic in the bench: signed range tests for overflow and an unsigned comparison for subtract carry.

// File: rtl/octo_alu_pkg.sv
package octo_alu_pkg;

    localparam int FN_W   = 3;
    localparam int FLAG_W = 4;

    typedef enum logic [FN_W-1:0] {
        FN_ADD  = 3'b000,
        FN_SUB  = 3'b001,
        FN_AND  = 3'b010,
        FN_XOR  = 3'b011,
        FN_NAND = 3'b100,
        FN_XNOR = 3'b101,
        FN_OR   = 3'b110,
        FN_NOR  = 3'b111
    } alu_fn_e;

    typedef enum logic [1:0] {
        BASE_AND = 2'd0,
        BASE_XOR = 2'd1,
        BASE_OR  = 2'd2
    } bit_base_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic carry;
        logic ovf;
    } alu_flags_t;

    function automatic logic fn_is_arith(alu_fn_e fn);
        return (fn == FN_ADD) || (fn == FN_SUB);
    endfunction

    function automatic logic fn_inverts(alu_fn_e fn);
        return (fn == FN_NAND) || (fn == FN_XNOR) || (fn == FN_NOR);
    endfunction

    function automatic bit_base_e fn_base(alu_fn_e fn);
        bit_base_e b;
        case (fn)
            FN_AND, FN_NAND: b = BASE_AND;
            FN_XOR, FN_XNOR: b = BASE_XOR;
            default:         b = BASE_OR;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/octo_alu_adder.sv
module octo_alu_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide_sum;

    always_comb begin
        b_eff    = sub_i ? ~b_i : b_i;
        wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
        sum_o    = wide_sum[WIDTH-1:0];
        carry_o  = wide_sum[WIDTH];
        ovf_o    = (a_i[MSB] == b_eff[MSB]) && (wide_sum[MSB] != a_i[MSB]);
    end

    always_comb begin
        if (sub_i) begin
            assert_sub_carry_R7: assert (carry_o == (a_i >= b_i))
                else $error("subtract carry disagrees with unsigned compare");
        end else begin
            assert_add_carry_R7: assert (carry_o == (sum_o < a_i))
                else $error("add carry disagrees with wraparound");
        end
        if (ovf_o) begin
            assert_ovf_sign_R8: assert (sum_o[MSB] != a_i[MSB])
                else $error("overflow without sign change");
        end
    end
endmodule

// File: rtl/octo_alu_bitwise.sv
module octo_alu_bitwise
    import octo_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  alu_fn_e          fn_i,
    output logic [WIDTH-1:0] res_o
);
    bit_base_e base;
    logic      inv;

    assign base = fn_base(fn_i);
    assign inv  = fn_inverts(fn_i);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic raw;
        always_comb begin
            case (base)
                BASE_AND: raw = a_i[i] & b_i[i];
                BASE_XOR: raw = a_i[i] ^ b_i[i];
                default:  raw = a_i[i] | b_i[i];
            endcase
        end
        assign res_o[i] = raw ^ inv;
    end

    always_comb begin
        if (fn_i == FN_XNOR) begin
            assert_xnor_parity_R4: assert ((res_o ^ a_i ^ b_i) == {WIDTH{1'b1}})
                else $error("XNOR result parity wrong");
        end
        if (fn_i == FN_NOR) begin
            assert_nor_disjoint_R4: assert ((res_o & (a_i | b_i)) == '0)
                else $error("NOR result overlaps operand ones");
        end
        if (fn_i == FN_AND) begin
            assert_and_subset_R3: assert ((res_o & ~a_i) == '0)
                else $error("AND result not a subset of A");
        end
    end
endmodule

// File: rtl/octo_alu_flags.sv
module octo_alu_flags
    import octo_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] res_i,
    input  logic             arith_i,
    input  logic             carry_i,
    input  logic             ovf_i,
    output alu_flags_t       flags_o
);
    always_comb begin
        flags_o.zero  = ~|res_i;
        flags_o.neg   = res_i[WIDTH-1];
        flags_o.carry = arith_i & carry_i;
        flags_o.ovf   = arith_i & ovf_i;
    end
endmodule

// File: rtl/octo_alu.sv
module octo_alu
    import octo_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    input  logic [FN_W-1:0]   fn_sel,
    output logic [WIDTH-1:0]  result,
    output logic [FLAG_W-1:0] flags
);
    alu_fn_e          fn;
    logic             arith;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] bits;
    logic             add_carry;
    logic             add_ovf;
    alu_flags_t       fl;

    assign fn    = alu_fn_e'(fn_sel);
    assign arith = fn_is_arith(fn);

    octo_alu_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i     (op_a),
        .b_i     (op_b),
        .sub_i   (fn == FN_SUB),
        .sum_o   (sum),
        .carry_o (add_carry),
        .ovf_o   (add_ovf)
    );

    octo_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i   (op_a),
        .b_i   (op_b),
        .fn_i  (fn),
        .res_o (bits)
    );

    assign result = arith ? sum : bits;

    octo_alu_flags #(.WIDTH(WIDTH)) u_flags (
        .res_i   (result),
        .arith_i (arith),
        .carry_i (add_carry),
        .ovf_i   (add_ovf),
        .flags_o (fl)
    );

    assign flags = fl;

    always_comb begin
        assert_zero_flag_R5: assert (flags[3] == (result == '0))
            else $error("zero flag mismatch");
        assert_neg_flag_R6: assert (flags[2] == result[WIDTH-1])
            else $error("negative flag mismatch");
        if (!arith) begin
            assert_logic_no_carry_R7: assert (flags[1] == 1'b0)
                else $error("carry set on bitwise function");
            assert_logic_no_overflow_R8: assert (flags[0] == 1'b0)
                else $error("overflow set on bitwise function");
        end
    end
endmodule

// File: tb/octo_alu_test.sv
module octo_alu_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [15:0] a16, b16, r16;
    logic [2:0]  f16, f4;
    logic [3:0]  fl16, fl4;
    logic [3:0]  a4, b4, r4;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    octo_alu #(.WIDTH(16)) uut (
        .op_a(a16), .op_b(b16), .fn_sel(f16), .result(r16), .flags(fl16)
    );
    octo_alu #(.WIDTH(4)) uut_narrow (
        .op_a(a4), .op_b(b4), .fn_sel(f4), .result(r4), .flags(fl4)
    );

    function automatic string res_tag(int fn);
        case (fn)
            0: return "R1";
            1: return "R2";
            4, 5, 7: return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic model(input int w, input longint a, input longint b, input int fn,
                         output longint res, output logic [3:0] fl);
        longint mask = (longint'(1) << w) - 1;
        longint half = longint'(1) << (w - 1);
        longint sa = (a >= half) ? a - 2 * half : a;
        longint sb = (b >= half) ? b - 2 * half : b;
        longint sr;
        logic c = 1'b0, v = 1'b0;
        case (fn)
            0: begin res = (a + b) & mask; c = ((a + b) > mask); sr = sa + sb;
                     v = (sr >= half) || (sr < -half); end
            1: begin res = (a - b) & mask; c = (a >= b); sr = sa - sb;
                     v = (sr >= half) || (sr < -half); end
            2: res = a & b;
            3: res = a ^ b;
            4: res = ~(a & b) & mask;
            5: res = ~(a ^ b) & mask;
            6: res = a | b;
            default: res = ~(a | b) & mask;
        endcase
        fl = {res == 0, res >= half, c, v};
    endtask

    task automatic cmp(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic judge(input logic [3:0] got, input logic [3:0] exp, input longint r,
                         input longint re, input int fn);
        cmp(res_tag(fn), r, re);
        cmp("R5 zero flag", got[3], exp[3]);
        cmp("R6 negative flag", got[2], exp[2]);
        cmp("R7 carry flag", got[1], exp[1]);
        cmp("R8 overflow flag", got[0], exp[0]);
    endtask

    task automatic run16(input logic [15:0] a, input logic [15:0] b, input int fn);
        longint re; logic [3:0] fe;
        @(posedge clk);
        a16 = a; b16 = b; f16 = 3'(fn);
        @(negedge clk);
        model(16, longint'(a), longint'(b), fn, re, fe);
        judge(fl16, fe, longint'(r16), re, fn);
    endtask

    logic [15:0] pool [12];

    initial begin
        a16 = '0; b16 = '0; f16 = '0; a4 = '0; b4 = '0; f4 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // idle inputs: ADD of zeros gives zero result and only the zero flag (R1, R5)
        cmp("R1 idle result", longint'(r16), 0);
        cmp("R5 idle flags", longint'(fl16), 8);

        // exhaustive narrow sweep
        for (int fn = 0; fn < 8; fn++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    longint re; logic [3:0] fe;
                    @(posedge clk);
                    a4 = 4'(a); b4 = 4'(b); f4 = 3'(fn);
                    @(negedge clk);
                    model(4, longint'(a), longint'(b), fn, re, fe);
                    judge(fl4, fe, longint'(r4), re, fn);
                end

        // full-width boundary words and pseudo-random words
        pool[0] = 16'h0000; pool[1] = 16'hFFFF; pool[2] = 16'h7FFF;
        pool[3] = 16'h8000; pool[4] = 16'h0001;
        begin
            int seed = 32'h1234;
            for (int i = 5; i < 12; i++) pool[i] = 16'($urandom(seed + i));
        end
        for (int fn = 0; fn < 8; fn++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    run16(pool[i], pool[j], fn);

        // directed full-width corners
        run16(16'h7FFF, 16'h0001, 0);   // R8 positive overflow on add
        run16(16'h8000, 16'h0001, 1);   // R8 negative overflow on subtract
        run16(16'hFFFF, 16'h0001, 0);   // R7 carry out with zero result, R5
        run16(16'h0000, 16'h0001, 1);   // R7 borrow gives carry 0, R6 negative
        run16(16'hFFFF, 16'hFFFF, 5);   // R4 XNOR all ones, no carry
        run16(16'h0000, 16'h0000, 7);   // R4 NOR all ones, R6

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule